// File: doc/BRIEF.md
# Memory Controller Configuration Register File

This block is the software-visible register file of a single memory controller on a system bus. It holds four 32-bit control words, named A to D, at word offsets 0 to 3. It also holds a boot ROM window of `ROM_WORDS` longwords that starts at word offset `ROM_BASE`. Every access on the register port carries a word offset, a read/write flag, a data word and the controller's mode: standard or extended memory. Exactly one cycle later the block returns the read data and a nonexistent-memory flag.

Writes do not simply replace whole words. Some fields take a new value only when an enable bit in the same data word is set. Some bits are write-one-to-clear, and which bits behave that way depends on the mode. Some bits always read as one. Word D is present only in extended mode. The values loaded at reset depend on the mode, on the array size in megabytes and on the controller's index. Error-logging logic outside the block can set bits in C and D through set inputs. The ROM is filled byte by byte through a separate load port.

Top module: `memctl_cfg_regs`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) loads the registers according to ext_mode. With ext_mode=1, A = (ARRAY_MB<<9)|0x6A and B = 0x3000|((CTRL_IDX*ARRAY_MB)<<15). With ext_mode=0, A = 0x7C10 and B = 0x3000|(CTRL_IDX<<21). In both modes C and D reset to 0.
- R2: A write to A (offset 0) always updates bit 8. It updates bits 2:0 only when bit 8 of the write data is 1. All other bits of A keep their value. A read of A returns the stored value AND 0x00107FFF.
- R3: A write to B (offset 1) updates bit 14 and bits 9:0. It updates the start-address field, bits 27:15, only when bit 14 of the write data is 1. All other bits of B keep their value.
- R4: A read of B returns the stored value AND 0xFFFFF7FF, OR 0x00003000. Bits 13:12 therefore always read as 1 and bit 11 always reads as 0.
- R5: In C (offset 2) and D (offset 3), a write sets bit 30 to the written value. A one on err_set_c or err_set_d sets the matching stored bit in the same cycle. Setting takes priority over clearing.
- R6: When C or D is written, each 1 in the write data clears the stored bit at that position if the position is inside the clear mask. The mask is 0x30000000 with ext_mode=0 and 0x300C0380 with ext_mode=1. Stored bits outside the mask and outside bit 30 are left unchanged by the write.
- R7: A read of C returns the stored value AND 0x7FFFFFFF with ext_mode=0, and AND 0x700C0380 with ext_mode=1. A read of D returns the stored value AND 0x700C0380.
- R8: The following accesses return rsp_nxm=1 and change no register: any access to D with ext_mode=0, and any access to offsets 4 up to ROM_BASE-1 or to offsets at or above ROM_BASE+ROM_WORDS.
- R9: A byte load on the ROM port replaces the byte lane given by rom_ld_addr[1:0] (lane 0 = bits 7:0) in longword rom_ld_addr[9:2]. The other three lanes stay unchanged. A read at offset ROM_BASE+n returns longword n.
- R10: A register-port write into the ROM window returns rsp_nxm=0 and leaves the ROM contents unchanged.
- R11: Every access is answered in the next cycle with rsp_valid=1. rsp_rdata is 0 for writes and for nonexistent-memory accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_mode | input | 1 | 1 = extended memory mode, 0 = standard mode |
| acc_valid | input | 1 | Register-port access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ofs | input | OFS_W | Word offset of the access |
| acc_wdata | input | 32 | Write data |
| err_set_c | input | 32 | Bits to set in word C |
| err_set_d | input | 32 | Bits to set in word D |
| rom_ld_en | input | 1 | ROM byte-load strobe |
| rom_ld_addr | input | ROM_AW+2 | Byte address inside the ROM window |
| rom_ld_byte | input | 8 | Byte to load |
| rsp_valid | output | 1 | Response strobe, one cycle after acc_valid |
| rsp_rdata | output | 32 | Read data |
| rsp_nxm | output | 1 | Nonexistent-memory error |

## Verification
Most internal faults stay hidden until software reads the affected word. Examples are a wrongly gated interleave or start-address field, a clear mask picked for the wrong mode, or a lost byte lane in the ROM. Each of these shows up in rsp_rdata one cycle after the next read of that word. For this reason the bench follows every write with a read-back. A decode fault is visible sooner, because it changes rsp_nxm in the same response cycle as the bad access.

// File: rtl/memctl_pkg.sv
package memctl_pkg;

  // Fixed field masks of the four control words
  localparam logic [31:0] A_RD_MASK   = 32'h0010_7FFF;
  localparam logic [31:0] A_FIXED_WR  = 32'h0000_0100;
  localparam logic [31:0] A_ILV_FIELD = 32'h0000_0007;
  localparam int          A_ILV_EN    = 8;
  localparam logic [31:0] A_EXT_TYPE  = 32'h0000_006A;
  localparam logic [31:0] A_STD_INIT  = 32'h0000_7C10;
  localparam int          A_SIZE_LSB  = 9;

  localparam logic [31:0] B_RD_MASK   = 32'hFFFF_F7FF;
  localparam logic [31:0] B_FIXED_WR  = 32'h0000_43FF;
  localparam logic [31:0] B_START     = 32'h0FFF_8000;
  localparam int          B_START_EN  = 14;
  localparam int          B_START_LSB = 15;
  localparam int          B_STD_IDX   = 21;
  localparam logic [31:0] B_FORCED    = 32'h0000_3000;

  localparam logic [31:0] CD_WR       = 32'h4000_0000;
  localparam logic [31:0] C_STD_RD    = 32'h7FFF_FFFF;
  localparam logic [31:0] CD_EXT_RD   = 32'h700C_0380;
  localparam logic [31:0] STD_CLR     = 32'h3000_0000;
  localparam logic [31:0] EXT_CLR     = 32'h300C_0380;

  function automatic logic [31:0] a_wr_mask(input logic [31:0] wd);
    return A_FIXED_WR | (wd[A_ILV_EN] ? A_ILV_FIELD : 32'h0);
  endfunction

  function automatic logic [31:0] b_wr_mask(input logic [31:0] wd);
    return B_FIXED_WR | (wd[B_START_EN] ? B_START : 32'h0);
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] wd,
                                        input logic [31:0] mask);
    return (old & ~mask) | (wd & mask);
  endfunction

  // Next value of C or D on a register-port write
  function automatic logic [31:0] cd_write(input logic [31:0] old, input logic [31:0] wd,
                                           input logic ext, input logic [31:0] set);
    logic [31:0] clr;
    clr = ext ? EXT_CLR : STD_CLR;
    return (merge(old, wd, CD_WR) & ~(wd & clr)) | set;
  endfunction

  function automatic logic [31:0] a_reset(input logic ext, input int mb);
    return ext ? ((32'(mb) << A_SIZE_LSB) | A_EXT_TYPE) : A_STD_INIT;
  endfunction

  function automatic logic [31:0] b_reset(input logic ext, input int idx, input int mb);
    return ext ? (B_FORCED | (32'(idx * mb) << B_START_LSB))
               : (B_FORCED | (32'(idx) << B_STD_IDX));
  endfunction

  function automatic logic [31:0] c_rd_mask(input logic ext);
    return ext ? CD_EXT_RD : C_STD_RD;
  endfunction

endpackage

// File: rtl/memctl_addr_dec.sv
module memctl_addr_dec #(
  parameter int OFS_W     = 11,
  parameter int REG_COUNT = 4,
  parameter int EXT_ONLY  = 3,
  parameter int ROM_BASE  = 'h400,
  parameter int ROM_WORDS = 256,
  localparam int ROM_AW   = $clog2(ROM_WORDS),
  localparam int ROM_END  = ROM_BASE + ROM_WORDS
) (
  input  logic [OFS_W-1:0]     ofs,
  input  logic                 ext_mode,
  output logic [REG_COUNT-1:0] sel_reg,
  output logic                 sel_rom,
  output logic [ROM_AW-1:0]    rom_idx,
  output logic                 nxm
);

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_sel
    if (i == EXT_ONLY) begin : g_ext
      assign sel_reg[i] = (ofs == OFS_W'(i)) && ext_mode;
    end else begin : g_any
      assign sel_reg[i] = (ofs == OFS_W'(i));
    end
  end

  assign sel_rom = (ofs >= OFS_W'(ROM_BASE)) && (ofs < OFS_W'(ROM_END));
  assign rom_idx = ROM_AW'(ofs - OFS_W'(ROM_BASE));
  assign nxm     = !(|sel_reg) && !sel_rom;

endmodule

// File: rtl/memctl_ctl_regs.sv
module memctl_ctl_regs
  import memctl_pkg::*;
#(
  parameter int ARRAY_MB = 4,
  parameter int CTRL_IDX = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_mode,
  input  logic        wr_en,
  input  logic [3:0]  sel,
  input  logic [31:0] wdata,
  input  logic [31:0] err_set_c,
  input  logic [31:0] err_set_d,
  output logic [3:0][31:0] rd_word
);

  logic [31:0] reg_a, reg_b, reg_c, reg_d;
  logic wr_a, wr_b, wr_c, wr_d;

  assign wr_a = wr_en && sel[0];
  assign wr_b = wr_en && sel[1];
  assign wr_c = wr_en && sel[2];
  assign wr_d = wr_en && sel[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= a_reset(ext_mode, ARRAY_MB);
      reg_b <= b_reset(ext_mode, CTRL_IDX, ARRAY_MB);
      reg_c <= '0;
      reg_d <= '0;
    end else begin
      if (wr_a) reg_a <= merge(reg_a, wdata, a_wr_mask(wdata));
      if (wr_b) reg_b <= merge(reg_b, wdata, b_wr_mask(wdata));
      reg_c <= wr_c ? cd_write(reg_c, wdata, ext_mode, err_set_c) : (reg_c | err_set_c);
      reg_d <= wr_d ? cd_write(reg_d, wdata, ext_mode, err_set_d) : (reg_d | err_set_d);
    end
  end

  assign rd_word[0] = reg_a & A_RD_MASK;
  assign rd_word[1] = (reg_b & B_RD_MASK) | B_FORCED;
  assign rd_word[2] = reg_c & c_rd_mask(ext_mode);
  assign rd_word[3] = reg_d & CD_EXT_RD;

  // R2
  ilv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a && !wdata[A_ILV_EN] |=> $stable(reg_a[2:0]));

  // R3
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b && !wdata[B_START_EN] |=> $stable(reg_b[27:15]));

  // R8
  d_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode && (err_set_d == 32'h0) |=> $stable(reg_d));

  // R5
  c_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set_c != 32'h0) |=> ((reg_c & $past(err_set_c)) == $past(err_set_c)));

endmodule

// File: rtl/memctl_boot_rom.sv
module memctl_boot_rom #(
  parameter int ROM_WORDS = 256,
  localparam int ROM_AW   = $clog2(ROM_WORDS),
  localparam int LANES    = 4
) (
  input  logic              clk,
  input  logic              ld_en,
  input  logic [ROM_AW+1:0] ld_addr,
  input  logic [7:0]        ld_byte,
  input  logic [ROM_AW-1:0] rd_idx,
  output logic [31:0]       rd_word
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_mem [ROM_WORDS];
    logic       lane_hit;

    assign lane_hit = ld_en && (ld_addr[1:0] == 2'(l));

    always_ff @(posedge clk) begin
      if (lane_hit) lane_mem[ld_addr[ROM_AW+1:2]] <= ld_byte;
    end

    assign rd_word[8*l +: 8] = lane_mem[rd_idx];
  end

endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs #(
  parameter int ARRAY_MB  = 4,
  parameter int CTRL_IDX  = 1,
  parameter int OFS_W     = 11,
  parameter int ROM_BASE  = 'h400,
  parameter int ROM_WORDS = 256,
  localparam int ROM_AW   = $clog2(ROM_WORDS),
  localparam int REG_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [OFS_W-1:0]  acc_ofs,
  input  logic [31:0]       acc_wdata,
  input  logic [31:0]       err_set_c,
  input  logic [31:0]       err_set_d,
  input  logic              rom_ld_en,
  input  logic [ROM_AW+1:0] rom_ld_addr,
  input  logic [7:0]        rom_ld_byte,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_nxm
);

  logic [REG_COUNT-1:0]       sel_reg;
  logic                       sel_rom;
  logic [ROM_AW-1:0]          rom_idx;
  logic                       dec_nxm;
  logic [REG_COUNT-1:0][31:0] reg_rd;
  logic [31:0]                rom_rd;
  logic [31:0]                rd_mux;
  logic                       reg_wr;

  memctl_addr_dec #(
    .OFS_W(OFS_W), .REG_COUNT(REG_COUNT), .EXT_ONLY(3),
    .ROM_BASE(ROM_BASE), .ROM_WORDS(ROM_WORDS)
  ) u_dec (
    .ofs(acc_ofs), .ext_mode(ext_mode), .sel_reg(sel_reg),
    .sel_rom(sel_rom), .rom_idx(rom_idx), .nxm(dec_nxm)
  );

  assign reg_wr = acc_valid && acc_write;

  memctl_ctl_regs #(.ARRAY_MB(ARRAY_MB), .CTRL_IDX(CTRL_IDX)) u_regs (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .wr_en(reg_wr),
    .sel(sel_reg), .wdata(acc_wdata), .err_set_c(err_set_c),
    .err_set_d(err_set_d), .rd_word(reg_rd)
  );

  memctl_boot_rom #(.ROM_WORDS(ROM_WORDS)) u_rom (
    .clk(clk), .ld_en(rom_ld_en), .ld_addr(rom_ld_addr),
    .ld_byte(rom_ld_byte), .rd_idx(rom_idx), .rd_word(rom_rd)
  );

  always_comb begin
    rd_mux = sel_rom ? rom_rd : 32'h0;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (sel_reg[i]) rd_mux = rd_mux | reg_rd[i];
    end
    if (acc_write) rd_mux = 32'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_nxm   <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_nxm   <= acc_valid && dec_nxm;
      rsp_rdata <= (acc_valid && !dec_nxm) ? rd_mux : 32'h0;
    end
  end

  // R11
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);

  // R11
  nxm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_nxm |-> (rsp_valid && rsp_rdata == 32'h0));

  // R8
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $onehot0({sel_reg, sel_rom}));

endmodule

// File: tb/memctl_cfg_regs_tb.sv
module memctl_cfg_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [10:0] acc_ofs = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] err_set_c = '0;
  logic [31:0] err_set_d = '0;
  logic        rom_ld_en = 1'b0;
  logic [9:0]  rom_ld_addr = '0;
  logic [7:0]  rom_ld_byte = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_nxm;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  memctl_cfg_regs u_dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_ofs(acc_ofs), .acc_wdata(acc_wdata),
    .err_set_c(err_set_c), .err_set_d(err_set_d), .rom_ld_en(rom_ld_en),
    .rom_ld_addr(rom_ld_addr), .rom_ld_byte(rom_ld_byte),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_nxm(rsp_nxm)
  );

  typedef struct packed {
    logic        ext;
    logic        wr;
    logic [10:0] ofs;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        nxm;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  // Defaults: ARRAY_MB=4, CTRL_IDX=1, walked after an extended-mode reset
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 11'h000, 32'h0,        32'h0000_086A, 1'b0, 4'd1},  // R1
    '{1'b1, 1'b0, 11'h001, 32'h0,        32'h0002_3000, 1'b0, 4'd1},  // R1
    '{1'b1, 1'b1, 11'h000, 32'h0000_0005, 32'h0,        1'b0, 4'd2},  // R2
    '{1'b1, 1'b0, 11'h000, 32'h0,        32'h0000_086A, 1'b0, 4'd2},  // R2
    '{1'b1, 1'b1, 11'h000, 32'h0000_0105, 32'h0,        1'b0, 4'd2},  // R2
    '{1'b1, 1'b0, 11'h000, 32'h0,        32'h0000_096D, 1'b0, 4'd2},  // R2
    '{1'b1, 1'b1, 11'h000, 32'hFFFF_FEFF, 32'h0,        1'b0, 4'd2},  // R2
    '{1'b1, 1'b0, 11'h000, 32'h0,        32'h0000_086D, 1'b0, 4'd2},  // R2
    '{1'b1, 1'b1, 11'h001, 32'hFFFF_BFFF, 32'h0,        1'b0, 4'd3},  // R3
    '{1'b1, 1'b0, 11'h001, 32'h0,        32'h0002_33FF, 1'b0, 4'd4},  // R4
    '{1'b1, 1'b1, 11'h001, 32'h0ABC_4000, 32'h0,        1'b0, 4'd3},  // R3
    '{1'b1, 1'b0, 11'h001, 32'h0,        32'h0ABC_7000, 1'b0, 4'd4},  // R4
    '{1'b1, 1'b1, 11'h002, 32'h4000_0000, 32'h0,        1'b0, 4'd5},  // R5
    '{1'b1, 1'b0, 11'h002, 32'h0,        32'h4000_0000, 1'b0, 4'd5},  // R5
    '{1'b1, 1'b0, 11'h004, 32'h0,        32'h0,         1'b1, 4'd8},  // R8
    '{1'b1, 1'b0, 11'h3FF, 32'h0,        32'h0,         1'b1, 4'd8},  // R8
    '{1'b1, 1'b0, 11'h003, 32'h0,        32'h0,         1'b0, 4'd7},  // R7
    '{1'b0, 1'b0, 11'h003, 32'h0,        32'h0,         1'b1, 4'd8},  // R8
    '{1'b0, 1'b0, 11'h002, 32'h0,        32'h4000_0000, 1'b0, 4'd7},  // R7
    '{1'b1, 1'b1, 11'h002, 32'h0,        32'h0,         1'b0, 4'd5},  // R5
    '{1'b1, 1'b0, 11'h002, 32'h0,        32'h0,         1'b0, 4'd5}   // R5
  };

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got nxm/data %h expected %h", req, act, exp);
    end
  endtask

  // One access; result sampled at the negedge after the response edge
  task automatic access(input logic ext, input logic wr, input logic [10:0] ofs,
                        input logic [31:0] wd, output logic [32:0] res, output logic vld);
    @(negedge clk);
    ext_mode = ext; acc_valid = 1'b1; acc_write = wr; acc_ofs = ofs; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    res = {rsp_nxm, rsp_rdata};
    vld = rsp_valid;
  endtask

  task automatic do_reset(input logic ext);
    @(negedge clk);
    ext_mode = ext; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rom_load(input logic [9:0] a, input logic [7:0] b);
    @(negedge clk);
    rom_ld_en = 1'b1; rom_ld_addr = a; rom_ld_byte = b;
    @(negedge clk);
    rom_ld_en = 1'b0;
  endtask

  task automatic pulse_err(input logic [31:0] c, input logic [31:0] d);
    @(negedge clk);
    err_set_c = c; err_set_d = d;
    @(negedge clk);
    err_set_c = '0; err_set_d = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no finish expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [32:0] r;
    logic v;

    do_reset(1'b1);
    check("R11 idle", {32'h0, rsp_valid}, 33'h0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].ext, VECS[i].wr, VECS[i].ofs, VECS[i].wd, r, v);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), r, {VECS[i].nxm, VECS[i].exp});
      check($sformatf("R11 valid vec%0d", i), {32'h0, v}, 33'h1);
    end

    // R5 / R6 / R7: error bits, mode-dependent clear masks and read masks
    pulse_err(32'h700C_0381, 32'h0);
    access(1'b1, 1'b0, 11'h002, 32'h0, r, v);
    check("R7 C ext", r, {1'b0, 32'h700C_0380});
    access(1'b0, 1'b0, 11'h002, 32'h0, r, v);
    check("R5 C std", r, {1'b0, 32'h700C_0381});
    access(1'b0, 1'b1, 11'h002, 32'h300C_0380, r, v);
    check("R11 wr zero", r, {1'b0, 32'h0});
    access(1'b0, 1'b0, 11'h002, 32'h0, r, v);
    check("R6 std clear", r, {1'b0, 32'h000C_0381});
    access(1'b1, 1'b1, 11'h002, 32'h000C_0380, r, v);
    access(1'b0, 1'b0, 11'h002, 32'h0, r, v);
    check("R6 ext clear", r, {1'b0, 32'h0000_0001});

    // R8 / R6 on D
    pulse_err(32'h0, 32'h0000_0100);
    access(1'b0, 1'b1, 11'h003, 32'h4000_0100, r, v);
    check("R8 D std write", r, {1'b1, 32'h0});
    access(1'b1, 1'b0, 11'h003, 32'h0, r, v);
    check("R8 D untouched", r, {1'b0, 32'h0000_0100});
    access(1'b1, 1'b1, 11'h003, 32'h4000_0100, r, v);
    access(1'b1, 1'b0, 11'h003, 32'h0, r, v);
    check("R6 D ext", r, {1'b0, 32'h4000_0000});

    // R9 / R10: boot ROM window
    rom_load(10'h014, 8'h11);
    rom_load(10'h015, 8'h22);
    rom_load(10'h016, 8'h33);
    rom_load(10'h017, 8'h44);
    access(1'b1, 1'b0, 11'h405, 32'h0, r, v);
    check("R9 word", r, {1'b0, 32'h4433_2211});
    rom_load(10'h016, 8'hAA);
    access(1'b1, 1'b0, 11'h405, 32'h0, r, v);
    check("R9 lane", r, {1'b0, 32'h44AA_2211});
    access(1'b1, 1'b1, 11'h405, 32'hDEAD_BEEF, r, v);
    check("R10 write resp", r, {1'b0, 32'h0});
    access(1'b1, 1'b0, 11'h405, 32'h0, r, v);
    check("R10 unchanged", r, {1'b0, 32'h44AA_2211});
    access(1'b1, 1'b0, 11'h500, 32'h0, r, v);
    check("R8 past ROM", r, {1'b1, 32'h0});

    // R1: standard-mode reset
    do_reset(1'b0);
    access(1'b0, 1'b0, 11'h000, 32'h0, r, v);
    check("R1 A std", r, {1'b0, 32'h0000_7C10});
    access(1'b0, 1'b0, 11'h001, 32'h0, r, v);
    check("R1 B std", r, {1'b0, 32'h0020_3000});
    access(1'b0, 1'b0, 11'h002, 32'h0, r, v);
    check("R1 C std", r, {1'b0, 32'h0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule